// File: doc/BRIEF.md
# Serial Byte Transmitter with Even Parity

This block turns one byte into an asynchronous serial frame on a single output line. The frame starts with a low start bit. Eight data bits follow, least significant first. An even-parity bit comes next, and a high stop bit ends the frame. A one-cycle load request, accepted only while the line is idle, copies the byte into an internal shift register. A controller then steps the frame forward once per bit period.

The bit period comes from an external enable pulse, `tick_en`, that runs at sixteen times the baud rate. Each bit stays on the line for sixteen of these pulses. When the stop bit has been on the line for its full period, the `transmitted` flag goes high. It stays high until the next load is accepted, so the surrounding logic can see when another byte may be presented.

Top module: `uart_even_tx`

## Requirements
- R1: When `load` is high in a cycle in which no frame is in progress, `tx_data` is captured, and from the next cycle `txd` is low (start bit).
- R2: After the start bit, the eight data bits appear on `txd` from bit 0 up to bit 7; for example, 0xBA appears as 0,1,0,1,1,1,0,1.
- R3: Each bit of the frame (start, data, parity, stop) stays on `txd` for exactly 16 `tick_en` pulses, and `txd` changes only in the cycle after a pulse.
- R4: The ninth bit after the start bit is the XOR of the eight data bits, so the data bits and the parity bit together hold an even number of ones.
- R5: The stop bit is high. In the cycle after the 16th pulse of the stop bit, `transmitted` goes high, and it stays high while the line is idle.
- R6: While no frame is in progress, `txd` is high whatever `tick_en` does.
- R7: A `load` that arrives while a frame is in progress is ignored, and the frame in flight finishes with its original byte.
- R8: A synchronous active-high `rst` drives `txd` high and `transmitted` low and returns the block to idle, including in the middle of a frame.
- R9: `transmitted` goes low in the cycle after a load is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | One-cycle pulse at 16 times the baud rate |
| load | input | 1 | Request to send `tx_data` |
| tx_data | input | 8 | Byte to send, captured when a load is accepted |
| txd | output | 1 | Serial line, registered, high when idle |
| transmitted | output | 1 | High once the stop bit of the last frame has completed |

## Verification
The assertions take `tick_en` to be a single-cycle pulse. They also take a load that arrives in the same cycle as a pulse while idle to be counted from the next pulse on, so the start bit still lasts sixteen pulses. The stimulus raises `tick_en` for one cycle at a time and never raises it in the cycle of an accepted load. It drives `tx_data` only around the accepting edge, then scrambles it, which shows the byte was captured. The one load sent in the middle of a frame lines up with a pulse, so the rule that such a load is ignored is tested in the cycles where the controller is about to advance.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_START  = 3'd1,
    ST_DATA   = 3'd2,
    ST_PARITY = 3'd3,
    ST_STOP   = 3'd4
  } frame_state_t;
endpackage

// File: rtl/ser_bit_timer.sv
// Counts oversampling pulses inside a bit; flags the last pulse of each bit.
module ser_bit_timer #(
  parameter int OVERSAMPLE = 16,
  localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             tick_en,
  output logic [CNT_W-1:0] cnt_q,
  output logic             bit_end
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

  assign bit_end = active && tick_en && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt_q <= '0;
    end else if (tick_en) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ser_frame_fsm.sv
// Frame sequencer: start, data bits, parity, stop.
module ser_frame_fsm
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         bit_end,
  output frame_state_t state_q,
  output frame_state_t state_d,
  output logic         accept,
  output logic         shift_en,
  output logic         finish
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  logic [IDX_W-1:0] idx_q;

  assign accept   = (state_q == ST_IDLE) && load;
  assign shift_en = (state_q == ST_DATA) && bit_end;
  assign finish   = (state_q == ST_STOP) && bit_end;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (load)    state_d = ST_START;
      ST_START:  if (bit_end) state_d = ST_DATA;
      ST_DATA:   if (bit_end && idx_q == LAST_IDX) state_d = ST_PARITY;
      ST_PARITY: if (bit_end) state_d = ST_STOP;
      ST_STOP:   if (bit_end) state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept)        idx_q <= '0;
      else if (shift_en) idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/ser_shift_path.sv
// Shift register holding the frame's data; parity is captured at load time.
module ser_shift_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              shift_en,
  input  logic [DATA_W-1:0] din,
  output logic              next_lsb,
  output logic              parity_q
);
  logic [DATA_W-1:0] sr_q;

  // Value the line takes after this cycle while in the data phase.
  assign next_lsb = shift_en ? sr_q[1] : sr_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q     <= '0;
      parity_q <= 1'b0;
    end else if (accept) begin
      sr_q     <= din;
      parity_q <= ^din;
    end else if (shift_en) begin
      sr_q <= {1'b0, sr_q[DATA_W-1:1]};
    end
  end
endmodule

// File: rtl/uart_even_tx.sv
module uart_even_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16,
  localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              load,
  input  logic [DATA_W-1:0] tx_data,
  output logic              txd,
  output logic              transmitted
);
  frame_state_t     fsm_state, fsm_next;
  logic             accept, shift_en, finish, bit_end;
  logic             next_lsb, parity_q;
  logic [CNT_W-1:0] tick_cnt;
  logic             txd_d;

  ser_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) timer_i (
    .clk(clk), .rst(rst), .active(fsm_state != ST_IDLE),
    .tick_en(tick_en), .cnt_q(tick_cnt), .bit_end(bit_end)
  );

  ser_frame_fsm #(.DATA_W(DATA_W)) fsm_i (
    .clk(clk), .rst(rst), .load(load), .bit_end(bit_end),
    .state_q(fsm_state), .state_d(fsm_next), .accept(accept),
    .shift_en(shift_en), .finish(finish)
  );

  ser_shift_path #(.DATA_W(DATA_W)) path_i (
    .clk(clk), .rst(rst), .accept(accept), .shift_en(shift_en),
    .din(tx_data), .next_lsb(next_lsb), .parity_q(parity_q)
  );

  always_comb begin
    unique case (fsm_next)
      ST_START:  txd_d = 1'b0;
      ST_DATA:   txd_d = next_lsb;
      ST_PARITY: txd_d = parity_q;
      default:   txd_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txd         <= 1'b1;
      transmitted <= 1'b0;
    end else begin
      txd <= txd_d;
      if (accept)      transmitted <= 1'b0;
      else if (finish) transmitted <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_even_tx_chk.sv
module uart_even_tx_chk
  import uart_tx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_en,
  input logic             load,
  input logic             txd,
  input logic             transmitted,
  input frame_state_t     fsm_state,
  input logic [CNT_W-1:0] tick_cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

  assert_start_low_R1: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == ST_IDLE && load) |=> (txd == 1'b0 && fsm_state == ST_START));

  assert_clear_on_load_R9: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == ST_IDLE && load) |=> !transmitted);

  assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (rst)
    (fsm_state != ST_IDLE && !tick_en) |=> $stable(txd));

  assert_done_after_stop_R5: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == ST_STOP && tick_en && tick_cnt == LAST) |=> (transmitted && txd));

  assert_idle_high_R6: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == ST_IDLE && !load) |=> txd);

  assert_busy_ignores_load_R7: assert property (@(posedge clk) disable iff (rst)
    (fsm_state != ST_IDLE && !tick_en) |=> $stable(fsm_state));

  assert_reset_idle_R8: assert property (@(posedge clk)
    rst |=> (txd && !transmitted && fsm_state == ST_IDLE));
endmodule

bind uart_even_tx uart_even_tx_chk #(.OVERSAMPLE(OVERSAMPLE)) chk_i (
  .clk(clk), .rst(rst), .tick_en(tick_en), .load(load), .txd(txd),
  .transmitted(transmitted), .fsm_state(fsm_state), .tick_cnt(tick_cnt)
);

// File: tb/uart_even_tx_tb_top.sv
module uart_even_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       load = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       txd, transmitted;
  int         n_tests = 0;
  int         n_fail = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  uart_even_tx dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .load(load),
    .tx_data(tx_data), .txd(txd), .transmitted(transmitted)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick_one(input int gap);
    @(negedge clk) tick_en = 1'b1;
    @(negedge clk) tick_en = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  function automatic logic exp_bit(input logic [7:0] b, input int k);
    if (k == 0) return 1'b0;
    if (k <= 8) return b[k-1];
    if (k == 9) return ^b;
    return 1'b1;
  endfunction

  // Sends one frame and checks every bit period, pulse by pulse.
  task automatic send_frame(input logic [7:0] b, input int gap, input bit intrude);
    @(negedge clk) begin tx_data = b; load = 1'b1; end
    @(negedge clk) begin load = 1'b0; tx_data = ~b; end
    check(txd == 1'b0, "R1 start bit", txd, 0);
    check(!transmitted, "R9 transmitted cleared", transmitted, 0);
    for (int k = 0; k < 11; k++) begin
      bit bad = 1'b0;
      int got = exp_bit(b, k);
      for (int t = 0; t < 16; t++) begin
        if (txd !== exp_bit(b, k) || transmitted) begin bad = 1'b1; got = txd; end
        if (intrude && k == 4 && t == 15) load = 1'b1;
        tick_one(gap);
        load = 1'b0;
      end
      if (k == 0)      check(!bad, "R3 start held 16 ticks", got, exp_bit(b, k));
      else if (k <= 8) check(!bad, intrude ? "R2/R3/R7 data bit" : "R2/R3 data bit", got, exp_bit(b, k));
      else if (k == 9) check(!bad, "R4 even parity", got, exp_bit(b, k));
      else             check(!bad, "R5 stop bit", got, 1);
    end
    check(txd == 1'b1 && transmitted == 1'b1, "R5 transmitted after stop",
          {txd, transmitted}, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(txd == 1'b1 && !transmitted, "R8 reset state", {txd, transmitted}, 2);
    rst = 1'b0;
    begin
      bit bad = 1'b0;
      for (int i = 0; i < 20; i++) begin tick_one(0); if (txd !== 1'b1) bad = 1'b1; end
      check(!bad, "R6 idle high", bad ? 0 : 1, 1);
    end
    for (int v = 0; v < 256; v++) send_frame(8'(v), 0, 1'b0);
    send_frame(8'hBA, 2, 1'b1);
    send_frame(8'h00, 1, 1'b1);
    send_frame(8'hFF, 2, 1'b1);
    send_frame(8'h01, 0, 1'b1);
    begin
      bit bad = 1'b0;
      for (int i = 0; i < 40; i++) begin tick_one(0); if (txd !== 1'b1 || !transmitted) bad = 1'b1; end
      check(!bad, "R5 R6 idle after frame", bad ? 0 : 1, 1);
    end
    // Reset in the middle of a frame.
    @(negedge clk) begin tx_data = 8'h55; load = 1'b1; end
    @(negedge clk) load = 1'b0;
    for (int i = 0; i < 40; i++) tick_one(0);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check(txd == 1'b1 && !transmitted, "R8 reset mid-frame", {txd, transmitted}, 2);
    begin
      bit bad = 1'b0;
      for (int i = 0; i < 20; i++) begin tick_one(0); if (txd !== 1'b1) bad = 1'b1; end
      check(!bad, "R8 idle after reset", bad ? 0 : 1, 1);
    end
    send_frame(8'hA5, 1, 1'b0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule